// File: doc/BRIEF.md
# Sample-Tick Timer and Interrupt Arbiter

This block sits beside an embedded sound processor. It holds an 8-bit timer that counts audio sample ticks while its enable bit is set. It also collects interrupt events from up to eight numbered sources into a pending mask. The processor sees a single fast-interrupt line and an index register that names the event it should service.

When the timer wraps from its all-ones value, the block raises the timer event itself. Software can write the timer value and the enable bit through a small register port. It retires events by writing to a clear strobe. Only every fourth clear write takes effect, and each effective clear retires the lowest-numbered pending event and republishes the next one. Out of reset, the reset event is already pending.

All outputs are registered, and each changes on the clock edge that follows the strobe causing it. The asynchronous active-low reset is released through a two-stage synchronizer, so the block leaves reset two edges after `rst_n` rises.

Top module: `snd_tick_irq`

## Requirements
- R1: After reset the timer reads 0, only event 2 is pending, the index reads 2 and the fast-interrupt line is high.
- R2: The timer adds one on each edge where `tick_i` is high and the enable bit (bit 6 of a write with `reg_sel_i`=1) is set. With the enable bit clear, ticks leave the timer unchanged.
- R3: A counted tick while the timer reads 0xFF wraps it to 0x00 and raises event 2 on the same edge.
- R4: A write with `reg_sel_i`=0 loads `reg_wdata_i` into the timer and overrides a tick in the same cycle. No wrap event is raised then, even from 0xFF.
- R5: An arriving event number e replaces the index when the index reads 0 or e is smaller than it. Requests that arrive together are applied from the lowest number upward, so events 0 and 4 arriving together leave the index at 4.
- R6: The fast-interrupt line rises on the edge after an event enters an empty pending mask.
- R7: Clear writes are counted modulo 4. Only the fourth write of each group performs a clear, and writes 1 to 3 change no output.
- R8: A clear removes the lowest pending event and then loads the index with the lowest event still pending. If none is left, the index keeps its value.
- R9: The fast-interrupt line falls on the edge after a clear empties the pending mask. A clear on an empty mask still counts as the fourth write.
- R10: When a clear and a new event fall in the same cycle, the clear acts on the old mask first and the new event is merged afterward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle audio sample tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Write target: 0 timer value, 1 control (bit 6 enable) |
| reg_wdata_i | input | 8 | Write data |
| evt_req_i | input | 8 | One-cycle event request per event number |
| clr_wr_i | input | 1 | Clear register write strobe |
| timer_o | output | 8 | Current timer value |
| evt_idx_o | output | 3 | Pending event index |
| fiq_o | output | 1 | Fast-interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: eight events, an 8-bit timer, a divide-by-four clear and event 2 as both the timer and the reset event. With these values a wrap takes at most 256 ticks. Timer writes that preload values near 0xFF make wraps frequent, and the short clear group lets random stimulus run many clear, re-request and collision cases. Directed sequences pin down the index quirk where event 0 arrives together with other events, the tick/write collision at 0xFF, and a clear that empties the mask while a new event arrives.

// File: rtl/snd_tick_pkg.sv
package snd_tick_pkg;

  typedef enum logic {
    SEL_TIMER = 1'b0,
    SEL_CTRL  = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/snd_tick_timer.sv
module snd_tick_timer
  import snd_tick_pkg::*;
#(
  parameter int TMR_W  = 8,
  parameter int EN_BIT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             reg_wr_i,
  input  logic             reg_sel_i,
  input  logic [TMR_W-1:0] reg_wdata_i,
  output logic [TMR_W-1:0] timer_o,
  output logic             wrap_o
);

  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             en_q, en_d;
  logic             wr_tmr, wr_ctl, step, tmr_ce;

  always_comb begin
    wr_tmr = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_TIMER);
    wr_ctl = reg_wr_i && (reg_sel_e'(reg_sel_i) == SEL_CTRL);
    step   = tick_i && en_q;
    tmr_ce = wr_tmr || step;
    wrap_o = step && !wr_tmr && (tmr_q == TMR_MAX);
    if (wr_tmr) tmr_d = reg_wdata_i;
    else        tmr_d = tmr_q + {{(TMR_W-1){1'b0}}, 1'b1};
    en_d = reg_wdata_i[EN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_ce) begin
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (wr_ctl) begin
      en_q <= en_d;
    end
  end

  assign timer_o = tmr_q;

  // R2: counted tick advances by one
  p_tick_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && en_q && !wr_tmr) |=> (timer_o == $past(timer_o) + 1'b1));

  // R2: without a counted tick or write the timer holds
  p_tick_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick_i && en_q) && !wr_tmr) |=> $stable(timer_o));

  // R3: a wrap leaves the timer at zero
  p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (timer_o == '0));

  // R4: software write wins
  p_write_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tmr |=> (timer_o == $past(reg_wdata_i)));

endmodule

// File: rtl/snd_clr_divider.sv
module snd_clr_divider #(
  parameter int CLR_WRITES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_wr_i,
  output logic fire_o
);

  localparam int CNT_W = (CLR_WRITES > 2) ? $clog2(CLR_WRITES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_WRITES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    fire_o = clr_wr_i && (cnt_q == CNT_LAST);
    if (cnt_q == CNT_LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr_wr_i) begin
      cnt_q <= cnt_d;
    end
  end

  // R7: a completed group restarts the count
  p_group_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> (cnt_q == '0));

  // R7: idle cycles keep the count
  p_count_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr_i |=> $stable(cnt_q));

endmodule

// File: rtl/snd_evt_arbiter.sv
module snd_evt_arbiter #(
  parameter int NUM_EVT   = 8,
  parameter int RESET_EVT = 2,
  localparam int IDX_W    = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] req_i,
  input  logic               clr_fire_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               fiq_o
);

  localparam logic [NUM_EVT-1:0] MASK_RST = NUM_EVT'(1) << RESET_EVT;
  localparam logic [IDX_W-1:0]   IDX_RST  = IDX_W'(RESET_EVT);

  logic [NUM_EVT-1:0] mask_q, mask_d, mask_cl, low_bit;
  logic [IDX_W-1:0]   idx_q, idx_d, idx_cl;
  logic               fiq_q, fiq_d;
  logic               upd;

  // clear stage: acts on the stored mask
  always_comb begin
    low_bit = mask_q & (~mask_q + {{(NUM_EVT-1){1'b0}}, 1'b1});
    mask_cl = clr_fire_i ? (mask_q & ~low_bit) : mask_q;
    idx_cl  = idx_q;
    if (clr_fire_i && (mask_cl != '0)) begin
      for (int i = NUM_EVT - 1; i >= 0; i--) begin
        if (mask_cl[i]) idx_cl = IDX_W'(i);
      end
    end
  end

  // merge stage: new events applied lowest number first
  always_comb begin
    idx_d = idx_cl;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (req_i[i] && ((idx_d == '0) || (IDX_W'(i) < idx_d))) idx_d = IDX_W'(i);
    end
    mask_d = mask_cl | req_i;
    if ((mask_cl == '0) && (req_i != '0))      fiq_d = 1'b1;
    else if (clr_fire_i && (mask_cl == '0))    fiq_d = 1'b0;
    else                                       fiq_d = fiq_q;
    upd = clr_fire_i || (req_i != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      idx_q  <= IDX_RST;
      fiq_q  <= 1'b1;
    end else if (upd) begin
      mask_q <= mask_d;
      idx_q  <= idx_d;
      fiq_q  <= fiq_d;
    end
  end

  assign idx_o = idx_q;
  assign fiq_o = fiq_q;

  // R6 / R9: interrupt line tracks a non-empty mask
  p_fiq_tracks_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == (mask_q != '0));

  // R8: a clear with no new request retires exactly one event
  p_clear_retires_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire_i && (req_i == '0) && (mask_q != '0))
      |=> ($countones(mask_q) == $countones($past(mask_q)) - 1));

  // R9: the line only falls after a clear
  p_fiq_fall_on_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fiq_o) |-> $past(clr_fire_i));

  // R10: a request arriving with a clear keeps the line high
  p_merge_after_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fire_i && (req_i != '0)) |=> fiq_o);

endmodule

// File: rtl/snd_tick_irq.sv
module snd_tick_irq #(
  parameter int TMR_W      = 8,
  parameter int EN_BIT     = 6,
  parameter int NUM_EVT    = 8,
  parameter int TIMER_EVT  = 2,
  parameter int RESET_EVT  = 2,
  parameter int CLR_WRITES = 4,
  localparam int IDX_W     = $clog2(NUM_EVT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [TMR_W-1:0]   reg_wdata_i,
  input  logic [NUM_EVT-1:0] evt_req_i,
  input  logic               clr_wr_i,
  output logic [TMR_W-1:0]   timer_o,
  output logic [IDX_W-1:0]   evt_idx_o,
  output logic               fiq_o
);

  logic [1:0]         rst_sync_q;
  logic               rst_n_int;
  logic               wrap;
  logic               clr_fire;
  logic [NUM_EVT-1:0] req_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  snd_tick_timer #(
    .TMR_W (TMR_W),
    .EN_BIT(EN_BIT)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .tick_i     (tick_i),
    .reg_wr_i   (reg_wr_i),
    .reg_sel_i  (reg_sel_i),
    .reg_wdata_i(reg_wdata_i),
    .timer_o    (timer_o),
    .wrap_o     (wrap)
  );

  snd_clr_divider #(
    .CLR_WRITES(CLR_WRITES)
  ) u_clr (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .clr_wr_i(clr_wr_i),
    .fire_o  (clr_fire)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_req
    if (g == TIMER_EVT) begin : g_tmr
      assign req_all[g] = evt_req_i[g] | wrap;
    end else begin : g_ext
      assign req_all[g] = evt_req_i[g];
    end
  end

  snd_evt_arbiter #(
    .NUM_EVT  (NUM_EVT),
    .RESET_EVT(RESET_EVT)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .req_i     (req_all),
    .clr_fire_i(clr_fire),
    .idx_o     (evt_idx_o),
    .fiq_o     (fiq_o)
  );

endmodule

// File: tb/snd_tick_irq_tb_top.sv
module snd_tick_irq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_i, reg_wr_i, reg_sel_i, clr_wr_i;
  logic [7:0] reg_wdata_i, evt_req_i;
  logic [7:0] timer_o;
  logic [2:0] evt_idx_o;
  logic       fiq_o;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  // reference model state
  logic [7:0] m_timer, m_mask;
  logic [2:0] m_idx;
  logic       m_en, m_fiq;
  logic [1:0] m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  snd_tick_irq dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .reg_wr_i(reg_wr_i),
    .reg_sel_i(reg_sel_i), .reg_wdata_i(reg_wdata_i), .evt_req_i(evt_req_i),
    .clr_wr_i(clr_wr_i), .timer_o(timer_o), .evt_idx_o(evt_idx_o), .fiq_o(fiq_o)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input logic tk, input logic wr, input logic sel,
                            input logic [7:0] wd, input logic [7:0] rq, input logic cl);
    logic       roll, fire, found;
    logic [7:0] req;
    roll = tk && m_en && !(wr && !sel) && (m_timer == 8'hFF);
    if (wr && !sel)     m_timer = wd;
    else if (tk && m_en) m_timer = m_timer + 8'd1;
    if (wr && sel) m_en = wd[6];
    req  = rq | (roll ? 8'h04 : 8'h00);
    fire = cl && (m_cnt == 2'd3);
    if (cl) m_cnt = m_cnt + 2'd1;
    if (fire) begin
      found = 1'b0;
      for (int i = 0; i < 8; i++)
        if (!found && m_mask[i]) begin m_mask[i] = 1'b0; found = 1'b1; end
      found = 1'b0;
      for (int i = 0; i < 8; i++)
        if (!found && m_mask[i]) begin m_idx = 3'(i); found = 1'b1; end
      if (m_mask == 8'h00) m_fiq = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      if (req[i]) begin
        if (m_mask == 8'h00) m_fiq = 1'b1;
        m_mask[i] = 1'b1;
        if ((m_idx == 3'd0) || (3'(i) < m_idx)) m_idx = 3'(i);
      end
    end
  endtask

  // drive at a falling edge, compare at the next falling edge
  task automatic cycle(input string tag, input logic tk, input logic wr, input logic sel,
                       input logic [7:0] wd, input logic [7:0] rq, input logic cl);
    tick_i = tk; reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = wd;
    evt_req_i = rq; clr_wr_i = cl;
    model_step(tk, wr, sel, wd, rq, cl);
    @(posedge clk);
    @(negedge clk);
    tick_i = 1'b0; reg_wr_i = 1'b0; evt_req_i = 8'h00; clr_wr_i = 1'b0;
    check(tag, "timer", int'(timer_o), int'(m_timer));
    check(tag, "index", int'(evt_idx_o), int'(m_idx));
    check(tag, "fiq",   int'(fiq_o), int'(m_fiq));
  endtask

  task automatic idle(input string tag);
    cycle(tag, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
  endtask

  task automatic clear_group(input string tag);
    for (int k = 0; k < 4; k++) cycle(tag, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    logic tk, wr, sel, cl;
    logic [7:0] wd, rq;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; tick_i = 1'b0; reg_wr_i = 1'b0; reg_sel_i = 1'b0;
    reg_wdata_i = 8'h00; evt_req_i = 8'h00; clr_wr_i = 1'b0;
    m_timer = 8'h00; m_mask = 8'h04; m_idx = 3'd2; m_en = 1'b0; m_fiq = 1'b1; m_cnt = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check("R1", "timer", int'(timer_o), 0);
    check("R1", "index", int'(evt_idx_o), 2);
    check("R1", "fiq",   int'(fiq_o), 1);

    // R7: three writes do nothing; R9: fourth empties the mask
    for (int k = 0; k < 3; k++) cycle("R7", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    check("R7", "fiq after 3 writes", int'(fiq_o), 1);
    cycle("R9", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    check("R9", "fiq after group", int'(fiq_o), 0);
    check("R8", "index kept when empty", int'(evt_idx_o), 2);

    // R6 / R5: event 5 into empty mask, index stays 2
    cycle("R6", 1'b0, 1'b0, 1'b0, 8'h00, 8'h20, 1'b0);
    check("R6", "fiq rise", int'(fiq_o), 1);
    check("R5", "index not replaced by larger", int'(evt_idx_o), 2);
    cycle("R5", 1'b0, 1'b0, 1'b0, 8'h00, 8'h08, 1'b0);
    clear_group("R8");
    check("R8", "index after retiring 3", int'(evt_idx_o), 5);
    clear_group("R9");
    check("R9", "fiq falls", int'(fiq_o), 0);

    // R5: events 0 and 4 together
    cycle("R5", 1'b0, 1'b0, 1'b0, 8'h00, 8'h11, 1'b0);
    check("R5", "index with 0 and 4", int'(evt_idx_o), 4);
    clear_group("R8");
    check("R8", "index after retiring 0", int'(evt_idx_o), 4);
    clear_group("R9");

    // R4: write wins over tick, even at 0xFF
    cycle("R2", 1'b0, 1'b1, 1'b1, 8'h40, 8'h00, 1'b0);
    cycle("R4", 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
    cycle("R4", 1'b1, 1'b1, 1'b0, 8'h10, 8'h00, 1'b0);
    check("R4", "timer written", int'(timer_o), 16);
    check("R4", "no wrap event", int'(fiq_o), 0);
    cycle("R2", 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R2", "timer step", int'(timer_o), 17);

    // R3: wrap raises event 2
    cycle("R3", 1'b0, 1'b1, 1'b0, 8'hFF, 8'h00, 1'b0);
    cycle("R3", 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R3", "timer wrapped", int'(timer_o), 0);
    check("R3", "fiq on wrap", int'(fiq_o), 1);
    check("R3", "index on wrap", int'(evt_idx_o), 2);

    // R2: disabled timer ignores ticks
    cycle("R2", 1'b0, 1'b1, 1'b1, 8'h00, 8'h00, 1'b0);
    for (int k = 0; k < 3; k++) cycle("R2", 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0);
    check("R2", "timer held while disabled", int'(timer_o), 0);

    // R10: clear plus event 6 in the same cycle
    for (int k = 0; k < 3; k++) cycle("R10", 1'b0, 1'b0, 1'b0, 8'h00, 8'h00, 1'b1);
    cycle("R10", 1'b0, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1);
    check("R10", "index after clear then merge", int'(evt_idx_o), 2);
    check("R10", "fiq kept", int'(fiq_o), 1);
    clear_group("R9");
    check("R9", "empty after last clear", int'(fiq_o), 0);

    // random phase
    cycle("R2", 1'b0, 1'b1, 1'b1, 8'h40, 8'h00, 1'b0);
    for (int n = 0; n < 4000; n++) begin
      tk  = ($urandom % 4) != 0;
      wr  = ($urandom % 16) == 0;
      sel = ($urandom % 4) == 0;
      wd  = (($urandom % 2) == 0) ? 8'(8'hF0 + ($urandom % 16)) : 8'($urandom);
      if (sel) wd[6] = ($urandom % 8) != 0;
      rq  = (($urandom % 6) == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      if (($urandom % 40) == 0) rq = rq | 8'(1 << ($urandom % 8));
      cl  = ($urandom % 3) == 0;
      cycle("R5", tk, wr, sel, wd, rq, cl);
    end

    finish_run();
  end

endmodule